// File: doc/BRIEF.md
# Switch Port Drop Statistics Unit

This block counts the packets a three-port switch buffer manager throws away. The buffer manager sends one drop strobe per source port each cycle. Each strobe carries cause flags: the buffer had no room, the meter marked the packet red, or the packet was yellow and was picked for random discard. Every port has two saturating counters. The total counter counts every drop from that port. The rate counter counts only the drops caused by ingress rate limiting, that is red drops or random yellow drops.

Software or a statistics collector reads the counters through a small request port. The request gives a port index and a counter selection. The selection can also ask for a derived value: total minus rate, which is the number of drops caused only by lack of buffer space. The result is registered and appears one cycle after the request, marked by a valid flag.

Each counter can be cleared with its own synchronous strobe. Reading a counter never changes it. The read path is a two-state machine. In `RD_IDLE` no result is pending. In `RD_RESP` the result is valid. A request moves the machine from either state to `RD_RESP` (`IDLE->RESP`, `RESP->RESP`). A cycle without a request moves it to `RD_IDLE` (`RESP->IDLE`, `IDLE->IDLE`).

Top module: `drop_stat_unit`

## Requirements
- R1: After synchronous active-high reset, every counter is zero, `rd_valid` is low and `rd_data` is zero.
- R2: A strobe on `drop_vld[p]` with at least one cause flag set adds exactly one to the total counter of port p. The three ports count independently, including when strobes arrive on several ports in the same cycle.
- R3: A strobe on `drop_vld[p]` with `drop_red[p]` or `drop_yel[p]` set adds exactly one to the rate counter of port p. A strobe with several cause flags adds one to each affected counter, never two.
- R4: A strobe that has only `drop_nospace` set leaves the rate counter unchanged. A strobe with no cause flag set changes no counter.
- R5: `rd_sel` is encoded as follows: 0 returns the total count, 1 returns the rate count, and 2 returns total minus rate, clamped to 0 when rate exceeds total. Selection 3 returns 0, and so does any `rd_port` value of 3.
- R6: A counter at all-ones stays at all-ones on further increments.
- R7: `clr_total[p]` and `clr_rate[p]` each set only their own counter to 0. If a clear and an increment reach the same counter in the same cycle, the counter ends at 1.
- R8: A request raised with `rd_req` in cycle n gives `rd_valid` high and `rd_data` in cycle n+1. The data holds the counter values as they stood before the edge that ends cycle n. `rd_valid` is low in any cycle that follows a cycle without a request. Reading never changes a counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| drop_vld | input | NUM_PORTS | Per-port drop event strobe |
| drop_nospace | input | NUM_PORTS | Cause flag: no buffer space |
| drop_red | input | NUM_PORTS | Cause flag: red metering discard |
| drop_yel | input | NUM_PORTS | Cause flag: random yellow discard |
| clr_total | input | NUM_PORTS | Per-port clear of the total counter |
| clr_rate | input | NUM_PORTS | Per-port clear of the rate counter |
| rd_req | input | 1 | Read request |
| rd_port | input | PORT_W | Port index of the read |
| rd_sel | input | 2 | Counter selection of the read |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | CNT_W | Read result |

## Verification
Counter updates and clears take effect at the clock edge that samples them. A read issued in a later cycle therefore sees the new value. A read issued in the same cycle still sees the old value, and one test checks that on purpose. Each read result arrives exactly one cycle after its request. The bench drives inputs on the falling edge, waits one falling edge, and then samples `rd_valid` and `rd_data`. It keeps its own model of expected counts, updated by the same rules as the requirements. The saturation test uses an 8-bit counter width so that the limit can be reached within the run.

// File: rtl/drop_stat_pkg.sv
package drop_stat_pkg;

    typedef enum logic [1:0] {
        SEL_TOTAL   = 2'd0,
        SEL_RATE    = 2'd1,
        SEL_BUFONLY = 2'd2,
        SEL_NONE    = 2'd3
    } rd_sel_e;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_RESP = 1'b1
    } rd_state_e;

    typedef struct packed {
        logic no_space;
        logic red;
        logic yel_rand;
    } drop_cause_t;

endpackage

// File: rtl/drop_sat_counter.sv
module drop_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] CNT_MAX = '1;
    localparam logic [W-1:0] CNT_ONE = W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= inc ? CNT_ONE : '0;
        end else if (inc && (cnt != CNT_MAX)) begin
            cnt <= cnt + CNT_ONE;
        end
    end
endmodule

// File: rtl/drop_port_bank.sv
module drop_port_bank
    import drop_stat_pkg::*;
#(
    parameter int W = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ev_vld,
    input  drop_cause_t ev_cause,
    input  logic        clr_total,
    input  logic        clr_rate,
    output logic [W-1:0] total_cnt,
    output logic [W-1:0] rate_cnt
);
    logic inc_total;
    logic inc_rate;

    // Any cause counts once in the total; only metering causes count as rate drops.
    assign inc_total = ev_vld && (ev_cause.no_space || ev_cause.red || ev_cause.yel_rand);
    assign inc_rate  = ev_vld && (ev_cause.red || ev_cause.yel_rand);

    drop_sat_counter #(.W(W)) u_total (
        .clk (clk),
        .rst (rst),
        .inc (inc_total),
        .clr (clr_total),
        .cnt (total_cnt)
    );

    drop_sat_counter #(.W(W)) u_rate (
        .clk (clk),
        .rst (rst),
        .inc (inc_rate),
        .clr (clr_rate),
        .cnt (rate_cnt)
    );
endmodule

// File: rtl/drop_read_mux.sv
module drop_read_mux
    import drop_stat_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int W         = 32,
    parameter int PORT_W    = 2
) (
    input  logic [NUM_PORTS-1:0][W-1:0] total_arr,
    input  logic [NUM_PORTS-1:0][W-1:0] rate_arr,
    input  logic [PORT_W-1:0]           sel_port,
    input  logic [1:0]                  sel_kind,
    output logic [W-1:0]                data
);
    logic [W-1:0] tot_v;
    logic [W-1:0] rate_v;
    logic         port_ok;

    always_comb begin
        port_ok = (int'(sel_port) < NUM_PORTS);
        tot_v   = '0;
        rate_v  = '0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (int'(sel_port) == i) begin
                tot_v  = total_arr[i];
                rate_v = rate_arr[i];
            end
        end
    end

    always_comb begin
        data = '0;
        if (port_ok) begin
            unique case (rd_sel_e'(sel_kind))
                SEL_TOTAL:   data = tot_v;
                SEL_RATE:    data = rate_v;
                SEL_BUFONLY: data = (tot_v > rate_v) ? (tot_v - rate_v) : '0;
                SEL_NONE:    data = '0;
            endcase
        end
    end
endmodule

// File: rtl/drop_stat_unit.sv
module drop_stat_unit
    import drop_stat_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int CNT_W     = 32,
    parameter int PORT_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_PORTS-1:0] drop_vld,
    input  logic [NUM_PORTS-1:0] drop_nospace,
    input  logic [NUM_PORTS-1:0] drop_red,
    input  logic [NUM_PORTS-1:0] drop_yel,
    input  logic [NUM_PORTS-1:0] clr_total,
    input  logic [NUM_PORTS-1:0] clr_rate,
    input  logic                 rd_req,
    input  logic [PORT_W-1:0]    rd_port,
    input  logic [1:0]           rd_sel,
    output logic                 rd_valid,
    output logic [CNT_W-1:0]     rd_data
);
    logic [NUM_PORTS-1:0][CNT_W-1:0] total_q;
    logic [NUM_PORTS-1:0][CNT_W-1:0] rate_q;
    logic [CNT_W-1:0]                mux_data;
    rd_state_e                       rd_state;
    rd_state_e                       rd_state_nx;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        drop_cause_t cause;
        assign cause = '{no_space: drop_nospace[p], red: drop_red[p], yel_rand: drop_yel[p]};

        drop_port_bank #(.W(CNT_W)) u_bank (
            .clk       (clk),
            .rst       (rst),
            .ev_vld    (drop_vld[p]),
            .ev_cause  (cause),
            .clr_total (clr_total[p]),
            .clr_rate  (clr_rate[p]),
            .total_cnt (total_q[p]),
            .rate_cnt  (rate_q[p])
        );
    end

    drop_read_mux #(
        .NUM_PORTS (NUM_PORTS),
        .W         (CNT_W),
        .PORT_W    (PORT_W)
    ) u_mux (
        .total_arr (total_q),
        .rate_arr  (rate_q),
        .sel_port  (rd_port),
        .sel_kind  (rd_sel),
        .data      (mux_data)
    );

    // Read response state register
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_state <= RD_IDLE;
        end else begin
            rd_state <= rd_state_nx;
        end
    end

    always_comb begin
        rd_state_nx = rd_state;
        unique case (rd_state)
            RD_IDLE: rd_state_nx = rd_req ? RD_RESP : RD_IDLE;
            RD_RESP: rd_state_nx = rd_req ? RD_RESP : RD_IDLE;
        endcase
    end

    // Output process: capture the selected value on each request
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_req) begin
            rd_data <= mux_data;
        end
    end

    assign rd_valid = (rd_state == RD_RESP);
endmodule

// File: rtl/drop_stat_chk.sv
module drop_stat_chk #(
    parameter int NUM_PORTS = 3,
    parameter int CNT_W     = 32
) (
    input logic                            clk,
    input logic                            rst,
    input logic [NUM_PORTS-1:0]            drop_vld,
    input logic [NUM_PORTS-1:0]            drop_nospace,
    input logic [NUM_PORTS-1:0]            drop_red,
    input logic [NUM_PORTS-1:0]            drop_yel,
    input logic [NUM_PORTS-1:0]            clr_total,
    input logic [NUM_PORTS-1:0]            clr_rate,
    input logic                            rd_req,
    input logic                            rd_valid,
    input logic [NUM_PORTS-1:0][CNT_W-1:0] total_q,
    input logic [NUM_PORTS-1:0][CNT_W-1:0] rate_q
);
    localparam logic [CNT_W-1:0] LIM = '1;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        AST_TOTAL_STEP: assert property (@(posedge clk) disable iff (rst)
            (drop_vld[p] && (drop_nospace[p] || drop_red[p] || drop_yel[p]) && !clr_total[p] && total_q[p] != LIM)
            |=> total_q[p] == $past(total_q[p]) + ONE); // R2
        AST_RATE_STEP: assert property (@(posedge clk) disable iff (rst)
            (drop_vld[p] && (drop_red[p] || drop_yel[p]) && !clr_rate[p] && rate_q[p] != LIM)
            |=> rate_q[p] == $past(rate_q[p]) + ONE); // R3
        AST_RATE_IGNORES_SPACE: assert property (@(posedge clk) disable iff (rst)
            ((!drop_vld[p] || (!drop_red[p] && !drop_yel[p])) && !clr_rate[p])
            |=> $stable(rate_q[p])); // R4
        AST_TOTAL_SATURATES: assert property (@(posedge clk) disable iff (rst)
            (total_q[p] == LIM && !clr_total[p]) |=> total_q[p] == LIM); // R6
        AST_CLEAR_LOW: assert property (@(posedge clk) disable iff (rst)
            clr_total[p] |=> total_q[p] <= ONE); // R7
    end

    AST_RESP_VALID: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_valid); // R8
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rd_valid); // R8
endmodule

bind drop_stat_unit drop_stat_chk #(
    .NUM_PORTS (NUM_PORTS),
    .CNT_W     (CNT_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .drop_vld     (drop_vld),
    .drop_nospace (drop_nospace),
    .drop_red     (drop_red),
    .drop_yel     (drop_yel),
    .clr_total    (clr_total),
    .clr_rate     (clr_rate),
    .rd_req       (rd_req),
    .rd_valid     (rd_valid),
    .total_q      (total_q),
    .rate_q       (rate_q)
);

// File: tb/drop_stat_unit_tb_top.sv
`timescale 1ns/1ps
module drop_stat_unit_tb_top;
    localparam int NP   = 3;
    localparam int W    = 8;
    localparam int MAXV = (1 << W) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] drop_vld = '0, drop_nospace = '0, drop_red = '0, drop_yel = '0;
    logic [NP-1:0] clr_total = '0, clr_rate = '0;
    logic          rd_req = 1'b0;
    logic [1:0]    rd_port = '0;
    logic [1:0]    rd_sel = '0;
    logic          rd_valid;
    logic [W-1:0]  rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_t[NP];
    int exp_r[NP];

    always #5 clk = ~clk;

    drop_stat_unit #(.NUM_PORTS(NP), .CNT_W(W), .PORT_W(2)) dut_i (
        .clk (clk), .rst (rst),
        .drop_vld (drop_vld), .drop_nospace (drop_nospace),
        .drop_red (drop_red), .drop_yel (drop_yel),
        .clr_total (clr_total), .clr_rate (clr_rate),
        .rd_req (rd_req), .rd_port (rd_port), .rd_sel (rd_sel),
        .rd_valid (rd_valid), .rd_data (rd_data)
    );

    task automatic check(input string req, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic int exp_read(input int p, input int sel);
        if (p >= NP) return 0;
        case (sel)
            0: return exp_t[p];
            1: return exp_r[p];
            2: return (exp_t[p] > exp_r[p]) ? exp_t[p] - exp_r[p] : 0;
            default: return 0;
        endcase
    endfunction

    // One cycle of stimulus with the reference model updated per the requirements
    task automatic cycle(input logic [NP-1:0] v, input logic [NP-1:0] ns, input logic [NP-1:0] rd,
                         input logic [NP-1:0] yl, input logic [NP-1:0] ct, input logic [NP-1:0] cr);
        drop_vld = v; drop_nospace = ns; drop_red = rd; drop_yel = yl;
        clr_total = ct; clr_rate = cr;
        for (int p = 0; p < NP; p++) begin
            bit it = v[p] && (ns[p] || rd[p] || yl[p]);
            bit ir = v[p] && (rd[p] || yl[p]);
            if (ct[p]) exp_t[p] = it ? 1 : 0;
            else if (it && exp_t[p] < MAXV) exp_t[p]++;
            if (cr[p]) exp_r[p] = ir ? 1 : 0;
            else if (ir && exp_r[p] < MAXV) exp_r[p]++;
        end
        @(negedge clk);
        drop_vld = '0; drop_nospace = '0; drop_red = '0; drop_yel = '0;
        clr_total = '0; clr_rate = '0;
    endtask

    task automatic do_read(input int p, input int sel, output int d, output int v);
        rd_req = 1'b1; rd_port = 2'(p); rd_sel = 2'(sel);
        @(negedge clk);
        rd_req = 1'b0;
        v = int'(rd_valid);
        d = int'(rd_data);
    endtask

    task automatic check_read(input string req, input int p, input int sel);
        int d, v;
        do_read(p, sel, d, v);
        check({req, " valid"}, v, 1);
        check(req, d, exp_read(p, sel));
    endtask

    task automatic check_port(input string req, input int p);
        for (int s = 0; s < 3; s++) check_read(req, p, s);
    endtask

    task automatic t_reset;
        check("R1 rd_valid", int'(rd_valid), 0);
        check("R1 rd_data", int'(rd_data), 0);
        for (int p = 0; p < NP; p++) check_port("R1", p);
    endtask

    task automatic t_total;
        for (int i = 0; i < 3; i++) cycle(3'b001, 3'b001, 3'b000, 3'b000, '0, '0);
        cycle(3'b010, 3'b000, 3'b010, 3'b000, '0, '0);
        cycle(3'b111, 3'b001, 3'b010, 3'b100, '0, '0);
        for (int p = 0; p < NP; p++) check_port("R2", p);
    endtask

    task automatic t_rate;
        cycle(3'b100, 3'b000, 3'b000, 3'b100, '0, '0);
        cycle(3'b001, 3'b001, 3'b001, 3'b001, '0, '0);
        check_read("R3 total multi-cause", 0, 0);
        check_read("R3 rate multi-cause", 0, 1);
        check_read("R3 rate yellow", 2, 1);
    endtask

    task automatic t_nocause;
        cycle(3'b010, 3'b000, 3'b000, 3'b000, '0, '0);
        check_read("R4 no-cause total", 1, 0);
        cycle(3'b010, 3'b010, 3'b000, 3'b000, '0, '0);
        check_read("R4 space-only rate", 1, 1);
        check_read("R4 space-only total", 1, 0);
    endtask

    task automatic t_decode;
        check_read("R5 buffer-only p0", 0, 2);
        check_read("R5 buffer-only p1", 1, 2);
        check_read("R5 sel3", 0, 3);
        check_read("R5 port3", 3, 0);
    endtask

    task automatic t_clear;
        cycle('0, '0, '0, '0, 3'b001, 3'b000);
        check_read("R7 clear total", 0, 0);
        check_read("R7 rate kept", 0, 1);
        cycle(3'b100, 3'b000, 3'b100, 3'b000, 3'b000, 3'b100);
        check_read("R7 clear+inc rate", 2, 1);
        check("R7 model", exp_r[2], 1);
        cycle('0, '0, '0, '0, 3'b010, 3'b000);
        check_read("R5 clamp", 1, 2);
    endtask

    task automatic t_sat;
        for (int i = 0; i < MAXV + 5; i++) cycle(3'b100, 3'b000, 3'b100, 3'b000, '0, '0);
        check_read("R6 total sat", 2, 0);
        check_read("R6 rate sat", 2, 1);
        check("R6 model", exp_t[2], MAXV);
    endtask

    task automatic t_read;
        int d, v, old;
        old = exp_t[1];
        // read and event in the same cycle: result shows the value before the edge
        drop_vld = 3'b010; drop_red = 3'b010;
        rd_req = 1'b1; rd_port = 2'd1; rd_sel = 2'd0;
        @(negedge clk);
        drop_vld = '0; drop_red = '0;
        exp_t[1]++; exp_r[1]++;
        // back-to-back second request
        check("R8 same-cycle old value", int'(rd_data), old);
        check("R8 valid", int'(rd_valid), 1);
        rd_sel = 2'd0;
        @(negedge clk);
        rd_req = 1'b0;
        check("R8 back-to-back valid", int'(rd_valid), 1);
        check("R8 new value", int'(rd_data), exp_t[1]);
        @(negedge clk);
        check("R8 valid drops", int'(rd_valid), 0);
        check_read("R8 no side effect", 1, 0);
        check_read("R8 no side effect again", 1, 0);
    endtask

    initial begin
        #2_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int p = 0; p < NP; p++) begin exp_t[p] = 0; exp_r[p] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_total();
        t_rate();
        t_nocause();
        t_decode();
        t_clear();
        t_sat();
        t_read();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule